// File: doc/BRIEF.md
# Page-Write Load and Program Sequencer

This block is the write engine inside a byte-wide parallel EEPROM, run in one synchronous clock domain. A host issues byte loads through active-low chip-enable, output-enable and write-enable strobes, along with a 17-bit address and 8-bit data. The engine collects these loads in a 256-byte page buffer. The upper address bits name the page. The low eight bits name the byte within the page.

Loading ends after a quiet period with no new load, measured in clock cycles. The engine then runs a programming phase of fixed length. In that phase it writes every loaded byte to the storage array through a simple write port. Bytes that were not loaded are left as they were. While programming runs, `busy_o` is high and any read returns a status byte in place of array data. In the status byte, bit 7 is the inverse of bit 7 of the last byte loaded, and bit 6 flips on every read. When the engine is idle, a read returns the array byte at the current address.

Top module: `eeprom_page_writer`

## Requirements
- R1: A load commits its data to array address {page, byte}, where the page is `addr_i[16:8]` and the byte is `addr_i[7:0]`. All 256 byte positions of a page can be loaded in one operation.
- R2: An operation holds 1 to 256 loads. A single load followed by the quiet period is a complete one-byte write.
- R3: Programming begins exactly `WIN_CYC` cycles after the last accepted load if no other load is accepted in that time. A load accepted inside that span restarts the count. Two loads separated by more than the span are committed as two separate operations.
- R4: The loading phase has no length limit. Any number of loads, each arriving inside the span, keeps `busy_o` low for the whole time.
- R5: The first load of an operation fixes its page. A later load that carries a different page is dropped.
- R6: `busy_o` is high for exactly `PROG_CYC` cycles per operation. `mem_we_o` is asserted only while `busy_o` is high.
- R7: Array bytes in the page that were not loaded in the operation keep their previous contents. Other pages are not written.
- R8: While `busy_o` is high, a read (`ce_ni`=0, `oe_ni`=0) returns in bit 7 the inverse of bit 7 of the last byte loaded. After `busy_o` falls, a read returns the true array data.
- R9: While `busy_o` is high, bit 6 of the read data inverts on each new read. The bit starts at 0 after reset. It does not change while `busy_o` is low.
- R10: A write is accepted only when `ce_ni`=0, `we_ni`=0 and `oe_ni`=1. Holding `oe_ni` low, `we_ni` high or `ce_ni` high starts no operation.
- R11: The write condition must hold for `MIN_PULSE` consecutive cycles before a load is accepted. A shorter pulse changes nothing. A held pulse is accepted once.
- R12: Write strobes that arrive while `busy_o` is high are ignored.
- R13: After reset, `busy_o`, `mem_we_o` and `rdata_o` are 0. When idle, a read returns `mem_rdata_i`, with `mem_raddr_o` equal to `addr_i`. When no read is active, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address; page in the upper bits |
| data_i | input | 8 | Load data |
| rdata_o | output | 8 | Read data or status byte |
| busy_o | output | 1 | Programming in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_waddr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| mem_raddr_o | output | ADDR_W | Array read address |
| mem_rdata_i | input | 8 | Array read data |

## Verification
The hardest state to reach is a read during programming. It needs a completed load, an expired quiet span, and a read strobe before the fixed programming time runs out. The bench counts cycles from the release of the strobe, so it knows exactly when programming starts. It issues several short reads inside the busy interval and predicts bit 6 from its own count of status reads since reset. Rejected loads are checked the same way. Off-page loads, loads during programming, inhibited strobes and short pulses are each followed by a full wait. The bench then reads the array back to confirm that nothing changed.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  localparam int DATA_W = 8;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} eepw_state_e;
endpackage

// File: rtl/eepw_strobe_filter.sv
module eepw_strobe_filter #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic acc_o,
  output logic rd_act_o,
  output logic rd_rise_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          wr_act;
  logic [CW-1:0] cnt_q;
  logic          rd_q;

  assign wr_act    = ~ce_ni & ~we_ni & oe_ni;
  assign rd_act_o  = ~ce_ni & ~oe_ni;
  assign rd_rise_o = rd_act_o & ~rd_q;
  assign acc_o     = wr_act && (cnt_q == CW'(MIN_PULSE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd_act_o;
      if (!wr_act) cnt_q <= '0;
      else if (cnt_q != CW'(MIN_PULSE)) cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (MIN_PULSE > 1) begin : g_pulse_chk
      // an accepted strobe was already active in the previous cycle
      assert_min_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_o |-> $past(wr_act));
    end
  endgenerate

  // one acceptance per held strobe
  assert_single_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o);
endmodule

// File: rtl/eepw_page_buffer.sv
module eepw_page_buffer #(
  parameter int PAGE_BITS = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ld_i,
  input  logic                      clr_i,
  input  logic [PAGE_BITS-1:0]      ld_idx_i,
  input  logic [eepw_pkg::DATA_W-1:0] ld_data_i,
  input  logic [PAGE_BITS-1:0]      rd_idx_i,
  output logic [eepw_pkg::DATA_W-1:0] rd_data_o,
  output logic                      rd_valid_o
);
  localparam int PAGE = 1 << PAGE_BITS;

  logic [eepw_pkg::DATA_W-1:0] buf_q [PAGE];
  logic [PAGE-1:0]             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (ld_i) begin
      if (clr_i) valid_q <= PAGE'(1) << ld_idx_i;
      else       valid_q[ld_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ld_i) buf_q[ld_idx_i] <= ld_data_i;
  end

  assign rd_data_o  = buf_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];

  // a new operation starts with only its first byte marked
  assert_first_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && clr_i) |=> ($countones(valid_q) == 1));
endmodule

// File: rtl/eepw_prog_ctrl.sv
module eepw_prog_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int WIN_CYC   = 5000,
  parameter int PROG_CYC  = 500000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        acc_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [eepw_pkg::DATA_W-1:0] data_i,
  output logic                        ld_o,
  output logic                        clr_o,
  output logic [PAGE_BITS-1:0]        idx_o,
  input  logic [eepw_pkg::DATA_W-1:0] buf_data_i,
  input  logic                        buf_valid_i,
  output logic                        busy_o,
  output logic                        last7_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_waddr_o,
  output logic [eepw_pkg::DATA_W-1:0] mem_wdata_o
);
  import eepw_pkg::*;
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int PG_W = ADDR_W - PAGE_BITS;
  localparam int WW   = $clog2(WIN_CYC + 1);
  localparam int PW   = $clog2(PROG_CYC + 1) > PAGE_BITS + 1 ? $clog2(PROG_CYC + 1) : PAGE_BITS + 1;
  // PROG_CYC must be at least PAGE so every buffer slot gets a write slot

  eepw_state_e      st_q;
  logic [PG_W-1:0]  page_q;
  logic [WW-1:0]    win_q;
  logic [PW-1:0]    prog_q;
  logic             last7_q;
  logic [PG_W-1:0]  pg_in;
  logic             in_range;

  assign pg_in    = addr_i[ADDR_W-1:PAGE_BITS];
  assign clr_o    = acc_i && (st_q == ST_IDLE);
  assign ld_o     = clr_o || (acc_i && (st_q == ST_LOAD) && (pg_in == page_q));
  assign busy_o   = (st_q == ST_PROG);
  assign last7_o  = last7_q;
  assign in_range = (prog_q < PW'(PAGE));
  assign idx_o    = busy_o ? prog_q[PAGE_BITS-1:0] : addr_i[PAGE_BITS-1:0];

  assign mem_we_o    = busy_o && in_range && buf_valid_i;
  assign mem_waddr_o = {page_q, prog_q[PAGE_BITS-1:0]};
  assign mem_wdata_o = buf_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      page_q  <= '0;
      win_q   <= '0;
      prog_q  <= '0;
      last7_q <= 1'b0;
    end else begin
      if (ld_o) last7_q <= data_i[DATA_W-1];
      unique case (st_q)
        ST_IDLE: if (acc_i) begin
          st_q   <= ST_LOAD;
          page_q <= pg_in;
          win_q  <= '0;
        end
        ST_LOAD: begin
          if (acc_i) win_q <= '0;
          else if (win_q == WW'(WIN_CYC - 1)) begin
            st_q   <= ST_PROG;
            prog_q <= '0;
          end else win_q <= win_q + 1'b1;
        end
        ST_PROG: begin
          if (prog_q == PW'(PROG_CYC - 1)) st_q <= ST_IDLE;
          else prog_q <= prog_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_we_in_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  assert_page_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(page_q));
  assert_off_page_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD && acc_i && pg_in != page_q) |=> $stable(page_q) && $stable(last7_q));
  assert_write_page_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> $stable(mem_waddr_o[ADDR_W-1:PAGE_BITS]));
endmodule

// File: rtl/eepw_status.sv
module eepw_status (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        busy_i,
  input  logic                        rd_act_i,
  input  logic                        rd_rise_i,
  input  logic                        last7_i,
  input  logic [eepw_pkg::DATA_W-1:0] mem_rdata_i,
  output logic [eepw_pkg::DATA_W-1:0] rdata_o
);
  import eepw_pkg::*;
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (busy_i && rd_rise_i) tog_q <= ~tog_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_act_i) begin
      if (busy_i) rdata_o = {~last7_i, tog_q, {(DATA_W-2){1'b0}}};
      else        rdata_o = mem_rdata_i;
    end
  end

  assert_tog_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(tog_q));
  assert_tog_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_rise_i) |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int WIN_CYC   = 5000,
  parameter int PROG_CYC  = 500000,
  parameter int MIN_PULSE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [7:0]        mem_rdata_i
);
  logic acc, rd_act, rd_rise, ld, clr, last7, buf_valid;
  logic [PAGE_BITS-1:0] idx;
  logic [7:0] buf_data;

  assign mem_raddr_o = addr_i;

  eepw_strobe_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .acc_o(acc), .rd_act_o(rd_act), .rd_rise_o(rd_rise));

  eepw_page_buffer #(.PAGE_BITS(PAGE_BITS)) u_buf (
    .clk_i, .rst_ni, .ld_i(ld), .clr_i(clr), .ld_idx_i(addr_i[PAGE_BITS-1:0]),
    .ld_data_i(data_i), .rd_idx_i(idx), .rd_data_o(buf_data), .rd_valid_o(buf_valid));

  eepw_prog_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WIN_CYC(WIN_CYC),
                   .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk_i, .rst_ni, .acc_i(acc), .addr_i, .data_i, .ld_o(ld), .clr_o(clr),
    .idx_o(idx), .buf_data_i(buf_data), .buf_valid_i(buf_valid), .busy_o,
    .last7_o(last7), .mem_we_o, .mem_waddr_o, .mem_wdata_o);

  eepw_status u_stat (
    .clk_i, .rst_ni, .busy_i(busy_o), .rd_act_i(rd_act), .rd_rise_i(rd_rise),
    .last7_i(last7), .mem_rdata_i, .rdata_o);

  assert_idle_read_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !ce_ni && !oe_ni) |-> (rdata_o == mem_rdata_i));
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int AW = 17, WIN = 16, PROG = 300, MP = 3;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, rdata, mem_wdata, mem_rdata;
  logic busy, mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;

  logic [7:0] mem [4096];
  logic [7:0] expm [4096];
  int checks = 0, errors = 0;
  bit tog_exp = 0;

  always #10 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(AW), .PAGE_BITS(8), .WIN_CYC(WIN), .PROG_CYC(PROG),
                       .MIN_PULSE(MP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .rdata_o(rdata), .busy_o(busy), .mem_we_o(mem_we),
    .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata), .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata));

  assign mem_rdata = mem[mem_raddr[11:0]];
  always @(posedge clk) if (mem_we) mem[mem_waddr[11:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int a, input int d, input int len);
    @(negedge clk);
    addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0;
    repeat (len) @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk);
    v = rdata;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!busy && n < WIN + 20) begin @(negedge clk); n++; end
    n = 0;
    while (busy && n < PROG + 20) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_page(input int pg, input string tag);
    int bad = 0, fa = 0, fv = 0, fe = 0;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) begin
      rd(pg * 256 + i, v);
      if (v !== expm[pg * 256 + i] && bad == 0) begin
        fa = pg * 256 + i; fv = v; fe = expm[pg * 256 + i];
      end
      if (v !== expm[pg * 256 + i]) bad++;
    end
    chk(bad == 0, $sformatf("%s page %0d addr %0h", tag, pg, fa), fv, fe);
  endtask

  initial begin
    logic [7:0] v, v2;
    int n;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'((i * 37 + 11) & 255);
      expm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk(busy == 0 && mem_we == 0 && rdata == 0, "R13 reset outputs", {busy, mem_we, rdata}, 0);
    rd(12'h105, v);
    chk(v == expm[12'h105], "R13 idle read", v, expm[12'h105]);

    // R2 R3 R6: single byte, exact window start and program length
    strobe(12'h123, 8'h5A, MP + 1);
    expm[12'h123] = 8'h5A;
    repeat (WIN - 3) @(negedge clk);
    chk(busy == 0, "R3 busy before window end", busy, 0);
    @(negedge clk);
    chk(busy == 1, "R3 busy at window end", busy, 1);
    n = 0;
    while (busy && n < PROG + 50) begin @(negedge clk); n++; end
    chk(n == PROG, "R6 program length", n, PROG);
    cmp_page(1, "R2 single byte");

    // R1: full page, every byte position
    for (int i = 0; i < 256; i++) begin
      strobe(3 * 256 + i, (i * 5 + 1) & 255, MP + 1);
      expm[3 * 256 + i] = 8'((i * 5 + 1) & 255);
    end
    wait_idle();
    cmp_page(3, "R1 full page");
    cmp_page(2, "R7 neighbour page");

    // R7: scattered bytes
    for (int i = 0; i < 6; i++) begin
      strobe(4 * 256 + i * 41, 8'hC0 + i, MP + 1);
      expm[4 * 256 + i * 41] = 8'(8'hC0 + i);
    end
    wait_idle();
    cmp_page(4, "R7 partial page");

    // R5: off-page load dropped
    strobe(5 * 256 + 1, 8'h11, MP + 1);
    strobe(6 * 256 + 2, 8'h22, MP + 1);
    expm[5 * 256 + 1] = 8'h11;
    wait_idle();
    cmp_page(5, "R5 first page");
    cmp_page(6, "R5 off page");

    // R8 R9: status reads during programming
    strobe(7 * 256 + 9, 8'h3C, MP + 1);
    expm[7 * 256 + 9] = 8'h3C;
    while (!busy) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      rd(7 * 256 + 9, v);
      tog_exp = ~tog_exp;
      chk(v[7] == 1'b1, "R8 inverted bit7", v[7], 1);
      chk(v[6] == tog_exp, "R9 toggle bit6", v[6], tog_exp);
    end
    // R12: strobe during programming ignored
    strobe(8 * 256, 8'hEE, MP + 1);
    wait_idle();
    rd(7 * 256 + 9, v);
    rd(7 * 256 + 9, v2);
    chk(v == 8'h3C && v2 == 8'h3C, "R8 R9 true data after", v2, 8'h3C);
    repeat (WIN + 5) @(negedge clk);
    chk(busy == 0, "R12 no late operation", busy, 0);
    cmp_page(8, "R12 busy strobe");

    // R8 with bit7 set
    strobe(7 * 256 + 10, 8'h81, MP + 1);
    expm[7 * 256 + 10] = 8'h81;
    while (!busy) @(negedge clk);
    rd(7 * 256 + 10, v);
    tog_exp = ~tog_exp;
    chk(v[7] == 1'b0 && v[6] == tog_exp, "R8 R9 status bit7 low", v, {1'b0, tog_exp, 6'b0});
    wait_idle();

    // R10: inhibit conditions
    @(negedge clk); addr = 9 * 256; din = 8'h55; ce_n = 0; we_n = 0; oe_n = 0;
    repeat (8) @(negedge clk); oe_n = 1; ce_n = 1; we_n = 1;
    @(negedge clk); ce_n = 0; we_n = 1; repeat (8) @(negedge clk); ce_n = 1;
    @(negedge clk); ce_n = 1; we_n = 0; repeat (8) @(negedge clk); we_n = 1;
    n = 0;
    for (int i = 0; i < WIN + 10; i++) begin @(negedge clk); n += busy; end
    chk(n == 0, "R10 inhibit no busy", n, 0);
    cmp_page(9, "R10 inhibit data");

    // R11: short pulse
    strobe(9 * 256 + 3, 8'h77, MP - 1);
    n = 0;
    for (int i = 0; i < WIN + 10; i++) begin @(negedge clk); n += busy; end
    chk(n == 0, "R11 short pulse no busy", n, 0);
    cmp_page(9, "R11 short pulse data");

    // R4: long loading phase
    n = 0;
    for (int i = 0; i < 60; i++) begin
      strobe(10 * 256 + (i * 3) % 256, i ^ 8'hA5, MP + 1 + (i % 6));
      expm[10 * 256 + (i * 3) % 256] = 8'(i ^ 8'hA5);
      n += busy;
    end
    chk(n == 0, "R4 no busy while loading", n, 0);
    wait_idle();
    cmp_page(10, "R4 long load");

    // R3: gap beyond window gives two operations
    strobe(11 * 256 + 1, 8'h01, MP + 1);
    repeat (WIN + 5) @(negedge clk);
    chk(busy == 1, "R3 first op started", busy, 1);
    wait_idle();
    strobe(12 * 256 + 2, 8'h02, MP + 1);
    expm[11 * 256 + 1] = 8'h01;
    expm[12 * 256 + 2] = 8'h02;
    wait_idle();
    cmp_page(11, "R3 split op A");
    cmp_page(12, "R3 split op B");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule